// File: doc/BRIEF.md
# Addressed Serial Command Receiver

This block listens on one asynchronous serial line shared by many stations. Every word on the line is eleven bits long: a low start bit, eight data bits sent least significant first, an even-parity bit and a high stop bit. The top data bit marks the word type: 1 for an address word and 0 for a command word. The lower seven bits hold either a station address or a command. The line idles high. Each bit is timed by a counter that divides the block clock by an oversampling factor, 64 by default. Every bit is sampled at its centre.

When an address word arrives intact and its seven bits equal the station address on `station_addr_i`, the block arms itself and gives a one-cycle pulse. The next word is then accepted if it is an intact command word. Its seven bits are latched onto `cmd_o` with a one-cycle strobe. The accepted command also raises a send-enable flag for a neighbouring transmitter. That flag drops when the transmitter raises `send_i`, or when a fixed window of bit times passes with no request.

Top module: `addr_cmd_rx`

## Requirements
- R1: While reset is asserted and just after it is released, `valid_addr_pulse_o`, `cmd_strobe_o` and `send_en_o` are 0 and `cmd_o` is all zeros.
- R2: A bit lasts OSR clock cycles and is sampled at its centre. Data arrives least significant bit first, and the line idles high. Bit 7 of the data byte is the word-type flag (1 = address, 0 = command), and bits 6..0 hold the payload.
- R3: A low level that has gone back high by half a bit time after its falling edge is not a start bit. It creates no word and does not change the armed state.
- R4: An address word with even parity over the data and parity bits, a high stop bit and a payload equal to `station_addr_i` gives exactly one `valid_addr_pulse_o` of one cycle, and arms the receiver.
- R5: An address word that does not match, or that has a parity or stop error, gives no pulse and disarms the receiver.
- R6: An intact command word that arrives while the receiver is armed loads its payload into `cmd_o` and gives exactly one `cmd_strobe_o` of one cycle.
- R7: A command word that arrives while the receiver is not armed gives no strobe and leaves `cmd_o` unchanged.
- R8: A command word with a parity error or a low stop bit gives no strobe, leaves `cmd_o` unchanged and disarms the receiver. After a low stop bit, a new start is looked for only once the line has returned high.
- R9: An accepted command sets `send_en_o` in the same cycle as the strobe. A rising edge on `send_i` while the flag is set clears it.
- R10: If no send request comes, `send_en_o` clears SEND_WIN_BITS*OSR cycles after it was set.
- R11: Each armed state accepts at most one command. A second command word needs a new matching address word first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Oversampling clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_i | input | 1 | Serial receive line, idles high |
| station_addr_i | input | DATA_W | Address of this station |
| send_i | input | 1 | Send request from the transmitter; its rising edge is used |
| valid_addr_pulse_o | output | 1 | One-cycle pulse when the address matches |
| cmd_o | output | DATA_W | Last accepted command |
| cmd_strobe_o | output | 1 | One-cycle pulse when a new command is loaded |
| send_en_o | output | 1 | Send-enable flag for the transmitter |

## Verification
The one-cycle pulse checks rely on words being at least a full frame apart. Bit timing makes this true for any line input, so the stimulus needs no special care there. The send-window check assumes the flag can only be set through a command strobe. The bench drives only whole bit periods of exactly OSR cycles and keeps `station_addr_i` fixed during a run, so the timing margin around each sampling point stays at half a bit. Random words are built with a chosen flag, payload, parity fault and stop fault. Checks are made a short idle gap after each stop bit, well inside the send window.

// File: rtl/acr_pkg.sv
package acr_pkg;
  typedef enum logic [1:0] {
    RX_IDLE  = 2'd0,
    RX_START = 2'd1,
    RX_BITS  = 2'd2,
    RX_HOLD  = 2'd3
  } rx_state_e;
endpackage

// File: rtl/acr_sync.sv
module acr_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  generate
    if (STAGES < 2) begin : g_single
      logic ff_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) ff_q <= RST_VAL;
        else         ff_q <= d_i;
      end
      assign q_o = ff_q;
    end else begin : g_chain
      logic [STAGES-1:0] ff_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) ff_q <= {STAGES{RST_VAL}};
        else         ff_q <= {ff_q[STAGES-2:0], d_i};
      end
      assign q_o = ff_q[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/acr_rx_core.sv
module acr_rx_core
  import acr_pkg::*;
#(
  parameter int OSR    = 64,
  parameter int WORD_W = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rx_i,
  output logic [WORD_W-1:0] word_o,
  output logic              done_o
);
  localparam int CW   = $clog2(OSR);
  localparam int IW   = $clog2(WORD_W + 1);
  localparam int HALF = OSR / 2;

  rx_state_e         st_q;
  logic [CW-1:0]     cnt_q;
  logic [IW-1:0]     idx_q;
  logic [WORD_W-1:0] sh_q;
  logic              done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= RX_IDLE;
      cnt_q  <= '0;
      idx_q  <= '0;
      sh_q   <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (st_q)
        RX_IDLE: begin
          if (!rx_i) begin
            st_q  <= RX_START;
            cnt_q <= '0;
          end
        end
        RX_START: begin
          if (cnt_q == CW'(HALF - 1)) begin
            cnt_q <= '0;
            idx_q <= '0;
            // line back high at mid-start: glitch
            st_q  <= rx_i ? RX_IDLE : RX_BITS;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        RX_BITS: begin
          if (cnt_q == CW'(OSR - 1)) begin
            cnt_q <= '0;
            sh_q  <= {rx_i, sh_q[WORD_W-1:1]};
            idx_q <= idx_q + 1'b1;
            if (idx_q == IW'(WORD_W - 1)) begin
              done_q <= 1'b1;
              st_q   <= rx_i ? RX_IDLE : RX_HOLD;
            end
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        RX_HOLD: begin
          if (rx_i) st_q <= RX_IDLE;
        end
        default: st_q <= RX_IDLE;
      endcase
    end
  end

  assign word_o = sh_q;
  assign done_o = done_q;
endmodule

// File: rtl/acr_frame_eval.sv
module acr_frame_eval #(
  parameter int DATA_W = 7
) (
  input  logic [DATA_W+2:0] word_i,
  input  logic [DATA_W-1:0] station_addr_i,
  output logic              good_o,
  output logic              is_addr_o,
  output logic              match_o,
  output logic [DATA_W-1:0] payload_o
);
  localparam int FLAG = DATA_W;
  localparam int PAR  = DATA_W + 1;
  localparam int STOP = DATA_W + 2;

  logic parity_ok;

  assign parity_ok = ~(^word_i[PAR:0]);
  assign good_o    = parity_ok & word_i[STOP];
  assign is_addr_o = word_i[FLAG];
  assign payload_o = word_i[DATA_W-1:0];
  assign match_o   = (word_i[DATA_W-1:0] == station_addr_i);
endmodule

// File: rtl/acr_ctrl.sv
module acr_ctrl #(
  parameter int DATA_W  = 7,
  parameter int WIN_CYC = 512
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              done_i,
  input  logic              good_i,
  input  logic              is_addr_i,
  input  logic              match_i,
  input  logic [DATA_W-1:0] payload_i,
  input  logic              send_rise_i,
  output logic              vap_o,
  output logic              strobe_o,
  output logic [DATA_W-1:0] cmd_o,
  output logic              send_en_o
);
  localparam int TW = (WIN_CYC > 1) ? $clog2(WIN_CYC) : 1;

  logic              armed_q;
  logic              vap_q;
  logic              stb_q;
  logic [DATA_W-1:0] cmd_q;
  logic              sen_q;
  logic [TW-1:0]     tmr_q;
  logic              addr_hit;
  logic              cmd_hit;

  assign addr_hit = done_i & good_i & is_addr_i & match_i;
  assign cmd_hit  = done_i & good_i & ~is_addr_i & armed_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q <= 1'b0;
      vap_q   <= 1'b0;
      stb_q   <= 1'b0;
      cmd_q   <= '0;
    end else begin
      vap_q <= addr_hit;
      stb_q <= cmd_hit;
      if (cmd_hit) cmd_q <= payload_i;
      // every finished word re-decides the armed state
      if (done_i) armed_q <= addr_hit;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sen_q <= 1'b0;
      tmr_q <= '0;
    end else if (cmd_hit) begin
      sen_q <= 1'b1;
      tmr_q <= '0;
    end else if (sen_q) begin
      if (send_rise_i || tmr_q == TW'(WIN_CYC - 1)) begin
        sen_q <= 1'b0;
        tmr_q <= '0;
      end else begin
        tmr_q <= tmr_q + 1'b1;
      end
    end
  end

  assign vap_o     = vap_q;
  assign strobe_o  = stb_q;
  assign cmd_o     = cmd_q;
  assign send_en_o = sen_q;
endmodule

// File: rtl/addr_cmd_rx.sv
module addr_cmd_rx #(
  parameter int OSR           = 64,
  parameter int DATA_W        = 7,
  parameter int SEND_WIN_BITS = 8,
  parameter int SYNC_STAGES   = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rx_i,
  input  logic [DATA_W-1:0] station_addr_i,
  input  logic              send_i,
  output logic              valid_addr_pulse_o,
  output logic [DATA_W-1:0] cmd_o,
  output logic              cmd_strobe_o,
  output logic              send_en_o
);
  localparam int WORD_W  = DATA_W + 3;
  localparam int WIN_CYC = OSR * SEND_WIN_BITS;

  logic              rx_s;
  logic              send_s;
  logic              send_q;
  logic              send_rise;
  logic [WORD_W-1:0] word;
  logic              done;
  logic              good;
  logic              is_addr;
  logic              match;
  logic [DATA_W-1:0] payload;

  acr_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_rx_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(rx_i), .q_o(rx_s)
  );

  acr_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_send_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(send_i), .q_o(send_s)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) send_q <= 1'b0;
    else         send_q <= send_s;
  end
  assign send_rise = send_s & ~send_q;

  acr_rx_core #(.OSR(OSR), .WORD_W(WORD_W)) u_core (
    .clk_i(clk_i), .rst_ni(rst_ni), .rx_i(rx_s), .word_o(word), .done_o(done)
  );

  acr_frame_eval #(.DATA_W(DATA_W)) u_eval (
    .word_i(word), .station_addr_i(station_addr_i), .good_o(good),
    .is_addr_o(is_addr), .match_o(match), .payload_o(payload)
  );

  acr_ctrl #(.DATA_W(DATA_W), .WIN_CYC(WIN_CYC)) u_ctrl (
    .clk_i(clk_i), .rst_ni(rst_ni), .done_i(done), .good_i(good),
    .is_addr_i(is_addr), .match_i(match), .payload_i(payload),
    .send_rise_i(send_rise), .vap_o(valid_addr_pulse_o),
    .strobe_o(cmd_strobe_o), .cmd_o(cmd_o), .send_en_o(send_en_o)
  );
endmodule

// File: rtl/acr_checker.sv
module acr_checker #(
  parameter int OSR           = 64,
  parameter int DATA_W        = 7,
  parameter int SEND_WIN_BITS = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              valid_addr_pulse_o,
  input logic [DATA_W-1:0] cmd_o,
  input logic              cmd_strobe_o,
  input logic              send_en_o
);
  localparam int WIN = OSR * SEND_WIN_BITS;
  localparam int CW  = $clog2(WIN + 2);

  logic [CW-1:0] win_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           win_q <= '0;
    else if (cmd_strobe_o) win_q <= CW'(1);
    else if (send_en_o)    win_q <= win_q + 1'b1;
    else                   win_q <= '0;
  end

  AST_VAP_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_addr_pulse_o |=> !valid_addr_pulse_o); // R4
  AST_STROBE_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_strobe_o |=> !cmd_strobe_o); // R6
  AST_CMD_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cmd_strobe_o |-> $stable(cmd_o)); // R7
  AST_SEND_FROM_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(send_en_o) |-> cmd_strobe_o); // R9
  AST_SEND_WINDOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (send_en_o && !cmd_strobe_o) |-> (win_q <= CW'(WIN - 1))); // R10
  AST_ONE_KIND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(valid_addr_pulse_o && cmd_strobe_o)); // R11
endmodule

bind addr_cmd_rx acr_checker #(
  .OSR(OSR), .DATA_W(DATA_W), .SEND_WIN_BITS(SEND_WIN_BITS)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .valid_addr_pulse_o(valid_addr_pulse_o),
  .cmd_o(cmd_o), .cmd_strobe_o(cmd_strobe_o), .send_en_o(send_en_o)
);

// File: tb/sim_addr_cmd_rx.sv
`timescale 1ns/1ps
module sim_addr_cmd_rx;
  localparam int OSR = 64;
  localparam int WINB = 8;
  localparam logic [6:0] ADDR = 7'h2D;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rx = 1'b1;
  logic send = 1'b0;
  logic vap, stb, sen;
  logic [6:0] cmd;

  int n_run = 0;
  int n_fail = 0;
  int vap_cnt = 0;
  int stb_cnt = 0;
  bit m_armed = 1'b0;
  logic [6:0] m_cmd = '0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  addr_cmd_rx #(.OSR(OSR), .DATA_W(7), .SEND_WIN_BITS(WINB)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .rx_i(rx), .station_addr_i(ADDR),
    .send_i(send), .valid_addr_pulse_o(vap), .cmd_o(cmd),
    .cmd_strobe_o(stb), .send_en_o(sen)
  );

  always @(negedge clk) begin
    if (vap) vap_cnt <= vap_cnt + 1;
    if (stb) stb_cnt <= stb_cnt + 1;
  end

  task automatic chk(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic drive_bit(input logic b);
    rx = b;
    idle(OSR);
  endtask

  function automatic logic exp_par(input logic [7:0] d);
    return ^d;
  endfunction

  // drive one word, then compare against the model
  task automatic frame(input logic [7:0] d, input bit perr, input bit serr,
                       input string req);
    bit good, exp_vap, exp_stb;
    vap_cnt = 0;
    stb_cnt = 0;
    drive_bit(1'b0);
    for (int i = 0; i < 8; i++) drive_bit(d[i]);
    drive_bit(exp_par(d) ^ perr);
    drive_bit(~serr);
    rx = 1'b1;
    idle(24);
    good    = !perr && !serr;
    exp_vap = good && d[7] && (d[6:0] == ADDR);
    exp_stb = good && !d[7] && m_armed;
    m_armed = exp_vap;
    if (exp_stb) m_cmd = d[6:0];
    chk({req, " vap"}, vap_cnt, int'(exp_vap));
    chk({req, " strobe"}, stb_cnt, int'(exp_stb));
    chk({req, " cmd"}, int'(cmd), int'(m_cmd));
    chk({req, " send_en"}, int'(sen), int'(exp_stb));
  endtask

  initial begin
    idle(5);
    chk("R1 vap", int'(vap), 0);
    chk("R1 strobe", int'(stb), 0);
    chk("R1 send_en", int'(sen), 0);
    chk("R1 cmd", int'(cmd), 0);
    rst_n = 1'b1;
    idle(10);
    chk("R1 vap after", int'(vap), 0);
    chk("R1 cmd after", int'(cmd), 0);

    // R2 R4 R6: basic address then command
    frame({1'b1, ADDR}, 0, 0, "R4");
    frame({1'b0, 7'h55}, 0, 0, "R6");
    // R10: window expiry
    idle(300);
    chk("R10 still set", int'(sen), 1);
    idle(260);
    chk("R10 expired", int'(sen), 0);

    // R7: command without arming
    frame({1'b0, 7'h12}, 0, 0, "R7");

    // R11: second command needs new address
    frame({1'b1, ADDR}, 0, 0, "R11 addr");
    frame({1'b0, 7'h2A}, 0, 0, "R11 first");
    frame({1'b0, 7'h33}, 0, 0, "R11 second");

    // R5: mismatch and bad parity address
    frame({1'b1, ADDR ^ 7'h01}, 0, 0, "R5 mismatch");
    frame({1'b0, 7'h44}, 0, 0, "R5 after mismatch");
    frame({1'b1, ADDR}, 1, 0, "R5 parity");
    frame({1'b0, 7'h45}, 0, 0, "R5 after parity");

    // R8: faulty command words disarm
    frame({1'b1, ADDR}, 0, 0, "R8 addr");
    frame({1'b0, 7'h66}, 1, 0, "R8 parity");
    frame({1'b0, 7'h67}, 0, 0, "R8 after parity");
    frame({1'b1, ADDR}, 0, 0, "R8 addr2");
    frame({1'b0, 7'h68}, 0, 1, "R8 stop");
    frame({1'b1, ADDR}, 0, 0, "R8 addr3");
    frame({1'b0, 7'h69}, 0, 0, "R8 recover");

    // R3: glitch keeps armed state and makes no word
    idle(600);
    frame({1'b1, ADDR}, 0, 0, "R3 addr");
    vap_cnt = 0;
    rx = 1'b0;
    idle(12);
    rx = 1'b1;
    idle(200);
    chk("R3 no word", vap_cnt, 0);
    frame({1'b0, 7'h1F}, 0, 0, "R3 cmd");

    // R9: send request clears flag
    frame({1'b1, ADDR}, 0, 0, "R9 addr");
    frame({1'b0, 7'h70}, 0, 0, "R9 cmd");
    send = 1'b1;
    idle(4);
    send = 1'b0;
    idle(8);
    chk("R9 cleared by send", int'(sen), 0);
    idle(600);

    // random mix
    void'($urandom(32'd1913));
    for (int k = 0; k < 40; k++) begin
      int sel;
      logic [7:0] d;
      sel = int'($urandom % 10);
      if (sel < 4)      d = {1'b1, ADDR};
      else if (sel < 6) d = {1'b1, 7'($urandom)};
      else              d = {1'b0, 7'($urandom)};
      frame(d, ($urandom % 10) == 0, ($urandom % 20) == 0, "R2 random");
    end
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule